// File: doc/BRIEF.md
# Inverted Page Table Translation Unit

This block turns a virtual address into a physical address using one system-wide translation table that holds one entry per physical frame. Every entry records which address space owns that frame and which virtual page of that address space is mapped there. Since each frame has exactly one entry, a frame belongs to at most one address space at a time, and no two address spaces can share a frame.

A lookup request carries an address space identifier, a virtual page number and a page offset. The unit walks the table from entry 0 upward at one entry per clock and stops at the first valid entry whose identifier and page number both equal the request. The position of that entry is the frame number. The frame number is placed above the page offset to form the physical address. When no entry matches, the unit returns a page-fault response instead.

Operating-system software loads entries through a separate write port. That port is held off while a lookup is in progress, so a search always sees one consistent table.

Top module: `inverted_pt_lookup`

## Requirements
- R1: After reset `req_ready` and `wr_ready` are 1, `rsp_valid` is 0, and every entry is invalid, so the first lookup returns a fault.
- R2: When `wr_en` and `wr_ready` are both 1 at a clock edge, the entry at `wr_frame` takes `wr_valid`, `wr_asid` and `wr_vpn` from that edge onward.
- R3: An entry matches a request only if it is valid and both its identifier and its page number equal the request's.
- R4: On a hit, `rsp_paddr` is `{frame_index, req_offset}`, where the frame index is the matching entry's position and occupies the upper bits. `rsp_fault` is 0.
- R5: When several entries match, the response carries the lowest matching index.
- R6: An entry written with `wr_valid`=0 never matches, whatever key it holds.
- R7: When no entry matches, `rsp_fault` is 1 and `rsp_paddr` is 0.
- R8: If a request is accepted at clock edge E, a hit at index k raises `rsp_valid` after edge E+k+2. A fault raises it after edge E+NUM_FRAMES+1.
- R9: `wr_ready` stays 0 from the accepting edge until the response has been taken. A write presented during that time changes nothing, and it takes effect once `wr_ready` returns to 1.
- R10: `rsp_valid`, `rsp_fault` and `rsp_paddr` hold steady until `rsp_ready` is 1 at an edge, and `req_ready` is 0 while a lookup or a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a lookup |
| req_asid | input | ASID_W | Address space identifier of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_offset | input | OFF_W | Page offset, passed through to the result |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | No matching entry (page fault) |
| rsp_paddr | output | IDX_W+OFF_W | Physical address: frame index above the offset |
| wr_en | input | 1 | Table write request |
| wr_ready | output | 1 | Table write is accepted this cycle |
| wr_frame | input | IDX_W | Entry (frame) to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_asid | input | ASID_W | Owner identifier to store |
| wr_vpn | input | VPN_W | Virtual page number to store |

## Verification
The bench builds the unit with 16 frames, a 4-bit identifier, a 6-bit page number and a 4-bit offset. With these sizes the whole key space of 1024 identifier and page pairs can be looked up against a filled table. Each expected frame index and each latency is computed by a first-match search over a model of the table. The small table also puts the last-entry hit, the full-length fault scan, duplicate keys and invalidated entries within a few thousand cycles. A write held off during a search can then be followed to the point where it lands.

// File: rtl/ivpt_pkg.sv
package ivpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } scan_state_e;

endpackage

// File: rtl/ivpt_table.sv
module ivpt_table #(
  parameter int NUM_FRAMES = 64,
  parameter int ASID_W     = 8,
  parameter int VPN_W      = 20,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_commit,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_valid,
  input  logic [ASID_W+VPN_W-1:0] wr_key,
  input  logic                    lock,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [ASID_W+VPN_W-1:0] rd_key,
  output logic                    rd_vld
);
  localparam int KEY_W = ASID_W + VPN_W;

  // Key storage: no reset, one write port, registered read (block RAM style)
  logic [KEY_W-1:0]      key_mem [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_commit) key_mem[wr_idx] <= wr_key;
    rd_key <= key_mem[rd_idx];
  end

  // Valid flags live in flops so reset can clear the whole table at once
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)
        vld_q[g] <= 1'b0;
      else if (wr_commit && (wr_idx == IDX_W'(g)))
        vld_q[g] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= vld_q[rd_idx];
  end

  // While a search runs, the table contents may not move
  p_table_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(vld_q));

endmodule

// File: rtl/ivpt_match.sv
module ivpt_match #(
  parameter int ASID_W = 8,
  parameter int VPN_W  = 20
) (
  input  logic              cmp_vld,
  input  logic              rd_vld,
  input  logic [ASID_W+VPN_W-1:0] rd_key,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VPN_W-1:0]  key_vpn,
  output logic              hit
);
  logic asid_eq;
  logic vpn_eq;

  always_comb begin
    asid_eq = (rd_key[ASID_W+VPN_W-1:VPN_W] == key_asid);
    vpn_eq  = (rd_key[VPN_W-1:0] == key_vpn);
    hit     = cmp_vld && rd_vld && asid_eq && vpn_eq;
  end

endmodule

// File: rtl/ivpt_ctrl.sv
module ivpt_ctrl
  import ivpt_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  parameter int ASID_W     = 8,
  parameter int VPN_W      = 20,
  parameter int OFF_W      = 12,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ASID_W-1:0]      req_asid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_offset,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_fault,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr,
  output logic                   wr_ready,
  output logic                   busy,
  output logic [IDX_W-1:0]       rd_idx,
  output logic                   cmp_vld,
  output logic [ASID_W-1:0]      key_asid,
  output logic [VPN_W-1:0]       key_vpn,
  input  logic                   cmp_hit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  scan_state_e      state_q;
  logic [IDX_W-1:0] issue_idx;
  logic             issuing;
  logic [IDX_W-1:0] cmp_idx;
  logic [OFF_W-1:0] key_off;

  assign req_ready = (state_q == ST_IDLE);
  assign wr_ready  = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rd_idx    = issue_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      issue_idx <= '0;
      issuing   <= 1'b0;
      cmp_idx   <= '0;
      cmp_vld   <= 1'b0;
      key_asid  <= '0;
      key_vpn   <= '0;
      key_off   <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cmp_vld <= 1'b0;
          if (req_valid) begin
            key_asid  <= req_asid;
            key_vpn   <= req_vpn;
            key_off   <= req_offset;
            issue_idx <= '0;
            issuing   <= 1'b1;
            state_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          // read issue stage: one entry address per cycle
          if (issuing) begin
            if (issue_idx == LAST_IDX) issuing <= 1'b0;
            else                       issue_idx <= issue_idx + 1'b1;
          end
          cmp_idx <= issue_idx;
          cmp_vld <= issuing;
          // compare stage: data registered by the table one cycle earlier
          if (cmp_hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {cmp_idx, key_off};
            issuing   <= 1'b0;
            cmp_vld   <= 1'b0;
            state_q   <= ST_RESP;
          end else if (cmp_vld && (cmp_idx == LAST_IDX)) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            issuing   <= 1'b0;
            cmp_vld   <= 1'b0;
            state_q   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_resp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_resp_taken_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

  p_no_accept_pending_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_hit_from_match_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && !rsp_fault) |-> $past(cmp_hit));

  p_fault_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_fault) |-> ($past(cmp_idx) == LAST_IDX));

endmodule

// File: rtl/inverted_pt_lookup.sv
module inverted_pt_lookup #(
  parameter int NUM_FRAMES = 64,
  parameter int ASID_W     = 8,
  parameter int VPN_W      = 20,
  parameter int OFF_W      = 12,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ASID_W-1:0]      req_asid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_offset,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_fault,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr,
  input  logic                   wr_en,
  output logic                   wr_ready,
  input  logic [IDX_W-1:0]       wr_frame,
  input  logic                   wr_valid,
  input  logic [ASID_W-1:0]      wr_asid,
  input  logic [VPN_W-1:0]       wr_vpn
);
  localparam int KEY_W = ASID_W + VPN_W;

  logic             wr_commit;
  logic             busy;
  logic [IDX_W-1:0] rd_idx;
  logic [KEY_W-1:0] rd_key;
  logic             rd_vld;
  logic             cmp_vld;
  logic             cmp_hit;
  logic [ASID_W-1:0] key_asid;
  logic [VPN_W-1:0]  key_vpn;

  assign wr_commit = wr_en && wr_ready;

  ivpt_table #(
    .NUM_FRAMES(NUM_FRAMES), .ASID_W(ASID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)
  ) table_i (
    .clk(clk), .rst(rst),
    .wr_commit(wr_commit), .wr_idx(wr_frame), .wr_valid(wr_valid),
    .wr_key({wr_asid, wr_vpn}),
    .lock(busy),
    .rd_idx(rd_idx), .rd_key(rd_key), .rd_vld(rd_vld)
  );

  ivpt_match #(.ASID_W(ASID_W), .VPN_W(VPN_W)) match_i (
    .cmp_vld(cmp_vld), .rd_vld(rd_vld), .rd_key(rd_key),
    .key_asid(key_asid), .key_vpn(key_vpn), .hit(cmp_hit)
  );

  ivpt_ctrl #(
    .NUM_FRAMES(NUM_FRAMES), .ASID_W(ASID_W), .VPN_W(VPN_W),
    .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_vpn(req_vpn), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .wr_ready(wr_ready), .busy(busy),
    .rd_idx(rd_idx), .cmp_vld(cmp_vld),
    .key_asid(key_asid), .key_vpn(key_vpn), .cmp_hit(cmp_hit)
  );

  // A write that the port accepts can only happen with the scan idle
  p_write_idle_only_r9: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (!rsp_valid && req_ready));

endmodule

// File: tb/inverted_pt_lookup_tb_top.sv
module inverted_pt_lookup_tb_top;
  localparam int NF = 16;
  localparam int AW = 4;
  localparam int VW = 6;
  localparam int OW = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_asid;
  logic [VW-1:0] req_vpn;
  logic [OW-1:0] req_offset;
  logic          rsp_valid, rsp_ready, rsp_fault;
  logic [IW+OW-1:0] rsp_paddr;
  logic          wr_en, wr_ready, wr_valid;
  logic [IW-1:0] wr_frame;
  logic [AW-1:0] wr_asid;
  logic [VW-1:0] wr_vpn;

  inverted_pt_lookup #(.NUM_FRAMES(NF), .ASID_W(AW), .VPN_W(VW), .OFF_W(OW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_vpn(req_vpn), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_frame(wr_frame),
    .wr_valid(wr_valid), .wr_asid(wr_asid), .wr_vpn(wr_vpn)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic          mdl_v [NF];
  logic [AW-1:0] mdl_a [NF];
  logic [VW-1:0] mdl_p [NF];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_find(input logic [AW-1:0] a, input logic [VW-1:0] p);
    for (int i = 0; i < NF; i++)
      if (mdl_v[i] && mdl_a[i] == a && mdl_p[i] == p) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // R2: store one entry through the write port
  task automatic write_entry(input int idx, input bit v, input logic [AW-1:0] a, input logic [VW-1:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = IW'(idx); wr_valid = v; wr_asid = a; wr_vpn = p;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    mdl_v[idx] = v; mdl_a[idx] = a; mdl_p[idx] = p;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic [VW-1:0] p,
                        input logic [OW-1:0] off, input string tag, input bit hold);
    int exp_idx;
    int n;
    logic [IW+OW-1:0] seen;
    exp_idx = ref_find(a, p);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_asid = a; req_vpn = p; req_offset = off;
    rsp_ready = !hold;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    // R8: latency counted in edges after the accepting edge
    chk(n == ((exp_idx < 0) ? NF + 1 : exp_idx + 2), {tag, " R8 latency"}, n,
        (exp_idx < 0) ? NF + 1 : exp_idx + 2);
    if (exp_idx < 0) begin
      chk(rsp_fault == 1'b1, {tag, " R7 fault"}, rsp_fault, 1);
      chk(rsp_paddr == '0, {tag, " R7 paddr"}, rsp_paddr, 0);
    end else begin
      chk(rsp_fault == 1'b0, {tag, " R3 fault"}, rsp_fault, 0);
      chk(rsp_paddr == {IW'(exp_idx), off}, {tag, " R4 paddr"}, rsp_paddr,
          longint'({IW'(exp_idx), off}));
    end
    if (hold) begin
      seen = rsp_paddr;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_paddr == seen, "R10 response held", rsp_paddr, seen);
        chk(req_ready == 1'b0, "R10 req_ready low while pending", req_ready, 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 response released", rsp_valid, 0);
    end
  endtask

  initial begin
    logic [AW-1:0] a15;
    logic [VW-1:0] p15, pnew;
    int n;
    rst = 1'b1; req_valid = 1'b0; req_asid = '0; req_vpn = '0; req_offset = '0;
    rsp_ready = 1'b1; wr_en = 1'b0; wr_frame = '0; wr_valid = 1'b0;
    wr_asid = '0; wr_vpn = '0;
    for (int i = 0; i < NF; i++) begin mdl_v[i] = 1'b0; mdl_a[i] = '0; mdl_p[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    lookup('0, '0, 4'h5, "R1 empty table", 1'b0);

    // R2: fill every frame with a distinct key
    for (int i = 0; i < NF; i++)
      write_entry(i, 1'b1, AW'(i * 3), VW'(i * 5 + 7));

    // R3: whole key space against the filled table
    for (int a = 0; a < (1 << AW); a++)
      for (int p = 0; p < (1 << VW); p++)
        lookup(AW'(a), VW'(p), OW'(a + p), "R3 sweep", 1'b0);

    // R4: every frame with several offsets
    for (int i = 0; i < NF; i++)
      lookup(mdl_a[i], mdl_p[i], OW'(15 - i), "R4 offset", 1'b0);

    // R5: duplicate key, lowest index wins
    write_entry(9, 1'b1, mdl_a[4], mdl_p[4]);
    lookup(mdl_a[4], mdl_p[4], 4'h3, "R5 first match", 1'b0);
    chk(ref_find(mdl_a[4], mdl_p[4]) == 4, "R5 model", ref_find(mdl_a[4], mdl_p[4]), 4);

    // R6: invalidated entries are skipped
    write_entry(4, 1'b0, mdl_a[4], mdl_p[4]);
    lookup(mdl_a[9], mdl_p[9], 4'hA, "R6 skip invalid", 1'b0);
    write_entry(3, 1'b0, mdl_a[3], mdl_p[3]);
    lookup(mdl_a[3], mdl_p[3], 4'h1, "R6 invalid only", 1'b0);

    // R10: response held under back-pressure
    lookup(mdl_a[7], mdl_p[7], 4'h6, "R10 hold", 1'b1);

    // R9: write presented during a search is held off
    a15 = mdl_a[15]; p15 = mdl_p[15]; pnew = p15 + VW'(32);
    @(negedge clk);
    req_valid = 1'b1; req_asid = a15; req_vpn = p15; req_offset = 4'h9;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_frame = 4'd15; wr_valid = 1'b1; wr_asid = a15; wr_vpn = pnew;
    n = 0;
    while (!rsp_valid && n < 200) begin
      chk(wr_ready == 1'b0, "R9 wr_ready low during search", wr_ready, 0);
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk(n == 17, "R9 R8 latency last entry", n, 17);
    chk(rsp_fault == 1'b0 && rsp_paddr == {4'd15, 4'h9}, "R9 search saw old table",
        rsp_paddr, longint'({4'd15, 4'h9}));
    chk(wr_ready == 1'b0, "R9 wr_ready low while response pending", wr_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R9 wr_ready back", wr_ready, 1);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    mdl_p[15] = pnew;
    lookup(a15, pnew, 4'h2, "R9 held write landed", 1'b0);
    lookup(a15, p15, 4'h2, "R9 old key gone", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule